// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling tick of a UART receiver or transmitter from a fast reference clock. Every bit period has 16 sub-ticks. Each sub-tick nominally lasts a whole number of reference clocks, given by an integer divisor. Selected sub-ticks are stretched by one extra clock so that the average bit period matches the target baud rate more closely than an integer divider alone can.

The stretched sub-ticks come from one of two sources. The first is a 16-bit slot mask, in which each bit stands for one sub-tick. The second is a 4-bit remainder count, which the block expands internally into an evenly spread pattern. The block outputs a one-clock sample tick at the end of every sub-tick and a bit strobe at the end of the sixteenth sub-tick.

New configuration values take effect only at a bit-period boundary, or at any time while the block is disabled. The serializer, deserializer and register access are handled elsewhere.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, both outputs stay 0. Once `rst_n` is released with `enable` high, the first cycle is the first clock of sub-tick 0.
- R2: While `enable` is low, both outputs stay 0. When `enable` rises, counting restarts at the first clock of sub-tick 0, whatever point was reached before.
- R3: Sub-tick i (i = 0 for the first sub-tick after a boundary, up to 15) lasts `div_int` + 1 + s_i reference clocks. In mask mode, s_i is bit i of `slot_mask`, with bit 0 the LSB.
- R4: `sample_tick` is high for exactly one clock, on the last reference clock of each sub-tick.
- R5: `bit_strobe` is high only in the cycle where `sample_tick` ends sub-tick 15. A full bit period therefore lasts 16·(`div_int`+1) plus the number of stretched sub-ticks.
- R6: When `use_rem` = 1, `slot_mask` is ignored, and sub-tick i is stretched when floor((i+1)·r/16) ≠ floor(i·r/16), where r is `rem_val`. This gives exactly r stretched sub-ticks per period.
- R7: When `use_rem` = 0, `rem_val` has no effect.
- R8: A change to `div_int`, `slot_mask`, `rem_val` or `use_rem` during a running bit period affects only the periods that follow it. The current period keeps the lengths latched at its start.
- R9: With `div_int` = 0 and no stretched sub-ticks, `sample_tick` is high on every reference clock and a bit period lasts 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low holds the counters at the start |
| div_int | input | DIV_W | Integer divisor; a sub-tick lasts div_int+1 clocks |
| slot_mask | input | 16 | Per-sub-tick stretch bits (mask mode) |
| rem_val | input | 4 | Number of stretched sub-ticks (remainder mode) |
| use_rem | input | 1 | 1 selects remainder mode, 0 selects mask mode |
| sample_tick | output | 1 | One-clock pulse ending each sub-tick |
| bit_strobe | output | 1 | One-clock pulse ending sub-tick 15 |

## Verification
The embedded properties run on every cycle. They check the following:
- the sub-tick counter never passes the length of the current sub-tick;
- the sub-tick index steps by one on every tick and returns to 0 after a bit strobe;
- counting restarts from zero when `enable` rises;
- the latched configuration holds still inside a bit period.

The exact placement of each tick is shown only by the bench scenarios, which compare every cycle against a model derived from the requirements. The same applies to the total period length for each mask and remainder pattern, the deferred effect of a mid-period divisor change, and the restart after a mid-period disable.

// File: rtl/frac_baud_pkg.sv
// Package: shared constants and the remainder-to-pattern expansion for the
// fractional baud tick generator. Assumes 16 sub-ticks per bit period.
package frac_baud_pkg;

    localparam int SUBTICKS = 16;
    localparam int SLOT_W   = $clog2(SUBTICKS);

    // Expands a remainder r into a 16-bit pattern with r bits set, spread evenly.
    function automatic logic [SUBTICKS-1:0] spread_mask(input logic [SLOT_W-1:0] r);
        logic [SUBTICKS-1:0] pat;
        for (int i = 0; i < SUBTICKS; i++) begin
            pat[i] = (((i + 1) * int'(r)) / SUBTICKS) != ((i * int'(r)) / SUBTICKS);
        end
        return pat;
    endfunction

endpackage

// File: rtl/frac_baud_cfg.sv
// Module: configuration shadow. Selects the stretch pattern (mask or expanded
// remainder) and latches it together with the divisor. Loads while held in
// reset or disabled, and at a bit-period boundary; holds otherwise.
module frac_baud_cfg
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                boundary,
    input  logic [DIV_W-1:0]    div_in,
    input  logic [SUBTICKS-1:0] mask_in,
    input  logic [SLOT_W-1:0]   rem_in,
    input  logic                use_rem,
    output logic [DIV_W-1:0]    div_q,
    output logic [SUBTICKS-1:0] mask_q
);

    logic [SUBTICKS-1:0] sel_mask;

    // Picks the stretch pattern source.
    always_comb begin
        sel_mask = use_rem ? spread_mask(rem_in) : mask_in;
    end

    // Shadows the configuration, updating only when no period is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || boundary) begin
            div_q  <= div_in;
            mask_q <= sel_mask;
        end
    end

    // Inside a running period the shadow must not move.
    property p_cfg_hold;
        @(posedge clk) disable iff (!rst_n)
        (enable && !boundary) |=> ($stable(div_q) && $stable(mask_q));
    endproperty
    assert_cfg_hold_R8: assert property (p_cfg_hold);

endmodule

// File: rtl/frac_baud_div.sv
// Module: sub-tick length counter. Counts reference clocks within a sub-tick
// and pulses tick on the last one. Length is div_q+1 plus the stretch bit.
// Assumes stretch and div_q only change when the counter is at zero.
module frac_baud_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_q,
    input  logic             stretch,
    output logic             tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;

    // Index of the final clock of the current sub-tick.
    always_comb begin
        last_val = {1'b0, div_q} + {{DIV_W{1'b0}}, stretch};
        tick     = rst_n && enable && (cnt == last_val);
    end

    // Advances the clock count, wrapping at the end of each sub-tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The count never overshoots the current sub-tick length.
    property p_cnt_bound;
        @(posedge clk) disable iff (!rst_n)
        cnt <= last_val;
    endproperty
    assert_cnt_bound_R3: assert property (p_cnt_bound);

    // A fresh enable always starts from the first clock.
    property p_restart;
        @(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> (cnt == '0);
    endproperty
    assert_restart_R2: assert property (p_restart);

endmodule

// File: rtl/frac_baud_slot.sv
// Module: sub-tick index within the bit period. Advances on every tick,
// wraps after the last sub-tick and flags the period end. Clears when disabled.
module frac_baud_slot
    import frac_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              period_end
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SUBTICKS - 1);

    // Marks the tick that closes the final sub-tick.
    always_comb begin
        period_end = tick && (slot_idx == LAST_SLOT);
    end

    // Steps the index once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            slot_idx <= '0;
        end else if (tick) begin
            slot_idx <= slot_idx + 1'b1;
        end
    end

    // A period end is followed by sub-tick 0.
    property p_wrap;
        @(posedge clk) disable iff (!rst_n)
        period_end |=> (slot_idx == '0);
    endproperty
    assert_wrap_R5: assert property (p_wrap);

    // A mid-period tick moves to the next sub-tick while enabled.
    property p_step;
        @(posedge clk) disable iff (!rst_n)
        (tick && (slot_idx != LAST_SLOT)) ##1 enable |-> (slot_idx == $past(slot_idx) + 1'b1);
    endproperty
    assert_step_R4: assert property (p_step);

endmodule

// File: rtl/frac_baud_gen.sv
// Module: fractional UART baud tick generator (top). Produces a 16x sample
// tick and a bit strobe from a reference clock using an integer divisor plus
// per-sub-tick single-clock stretching. Assumes config is static per period.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_int,
    input  logic [15:0]      slot_mask,
    input  logic [3:0]       rem_val,
    input  logic             use_rem,
    output logic             sample_tick,
    output logic             bit_strobe
);

    logic [DIV_W-1:0]    div_q;
    logic [SUBTICKS-1:0] mask_q;
    logic [SLOT_W-1:0]   slot_idx;
    logic                tick;
    logic                period_end;
    logic                stretch;

    // Stretch bit of the active sub-tick.
    always_comb begin
        stretch     = mask_q[slot_idx];
        sample_tick = tick;
        bit_strobe  = period_end;
    end

    frac_baud_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .boundary (period_end),
        .div_in   (div_int),
        .mask_in  (slot_mask),
        .rem_in   (rem_val),
        .use_rem  (use_rem),
        .div_q    (div_q),
        .mask_q   (mask_q)
    );

    frac_baud_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_q   (div_q),
        .stretch (stretch),
        .tick    (tick)
    );

    frac_baud_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .slot_idx   (slot_idx),
        .period_end (period_end)
    );

    // Nothing is emitted while held in reset.
    property p_quiet_reset;
        @(posedge clk) !rst_n |-> (!sample_tick && !bit_strobe);
    endproperty
    assert_quiet_reset_R1: assert property (p_quiet_reset);

endmodule

// File: tb/frac_baud_gen_tb.sv
// Bench: walks a vector table of configurations and compares every cycle with
// a model built from the requirements, then runs directed corner cases.
module frac_baud_gen_tb;

    typedef struct packed {
        logic [15:0] d;
        logic [15:0] m;
        logic [3:0]  r;
        logic        u;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'd0, 16'h0000, 4'd0,  1'b0},
        '{16'd3, 16'h0080, 4'd0,  1'b0},
        '{16'd2, 16'hFFDF, 4'd0,  1'b0},
        '{16'd0, 16'hFFFF, 4'd0,  1'b0},
        '{16'd1, 16'h0000, 4'd4,  1'b1},
        '{16'd0, 16'h0000, 4'd15, 1'b1},
        '{16'd5, 16'h0000, 4'd0,  1'b1},
        '{16'd4, 16'hFFFF, 4'd8,  1'b1},
        '{16'd2, 16'h0000, 4'd9,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_int = '0;
    logic [15:0] slot_mask = '0;
    logic [3:0]  rem_val = '0;
    logic        use_rem = 1'b0;
    logic        sample_tick;
    logic        bit_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .div_int     (div_int),
        .slot_mask   (slot_mask),
        .rem_val     (rem_val),
        .use_rem     (use_rem),
        .sample_tick (sample_tick),
        .bit_strobe  (bit_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sub_len(input vec_t v, input int i);
        int b;
        if (v.u) b = ((((i + 1) * int'(v.r)) / 16) != ((i * int'(v.r)) / 16)) ? 1 : 0;
        else     b = v.m[i] ? 1 : 0;
        return int'(v.d) + 1 + b;
    endfunction

    task automatic run_vec(input vec_t v, input string tag);
        int errs_t = 0, errs_s = 0, first_s = -1, n_s = 0, i = 0, k = 0, total;
        bit exp_t, exp_s;
        total = 16 * (int'(v.d) + 1) + (v.u ? int'(v.r) : $countones(v.m));
        enable = 1'b0;
        div_int = v.d; slot_mask = v.m; rem_val = v.r; use_rem = v.u;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int c = 1; c <= 2 * total; c++) begin
            #1;
            k++;
            exp_t = (k == sub_len(v, i));
            exp_s = exp_t && (i == 15);
            if (sample_tick !== exp_t) errs_t++;
            if (bit_strobe !== exp_s) errs_s++;
            if (bit_strobe === 1'b1) begin
                n_s++;
                if (first_s < 0) first_s = c;
            end
            if (exp_t) begin
                k = 0;
                i = (i + 1) % 16;
            end
            @(negedge clk);
        end
        check(errs_t == 0, {tag, " R3/R4 tick placement"}, errs_t, 0);
        check(errs_s == 0, {tag, " R5 strobe placement"}, errs_s, 0);
        check(first_s == total, {tag, " R5 period length"}, first_s, total);
        check(n_s == 2, {tag, " R5 strobes in two periods"}, n_s, 2);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt_t, s1, s2;
        string tag;

        // R1: outputs quiet in reset even with enable high and minimum divisor.
        enable = 1'b1;
        cnt_t = 0;
        repeat (6) begin
            @(negedge clk); #1;
            if (sample_tick || bit_strobe) cnt_t++;
        end
        check(cnt_t == 0, "R1 quiet in reset", cnt_t, 0);

        // R1: release with enable high starts at sub-tick 0.
        @(negedge clk);
        rst_n = 1'b1;
        s1 = -1;
        for (int c = 1; c <= 20; c++) begin
            #1;
            if (c == 1) check(sample_tick === 1'b1, "R1 first cycle tick", int'(sample_tick), 1);
            if (bit_strobe === 1'b1 && s1 < 0) s1 = c;
            @(negedge clk);
        end
        check(s1 == 16, "R1 first strobe after reset", s1, 16);

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].u)                                tag = "R6";
            else if (VECS[v].r != 0)                      tag = "R7";
            else if (VECS[v].d == 0 && VECS[v].m == 0)    tag = "R9";
            else                                          tag = "R3";
            run_vec(VECS[v], tag);
        end

        // R2: enable low suppresses ticks.
        enable = 1'b0;
        cnt_t = 0;
        repeat (12) begin
            @(negedge clk); #1;
            if (sample_tick || bit_strobe) cnt_t++;
        end
        check(cnt_t == 0, "R2 quiet while disabled", cnt_t, 0);

        // R2: mid-period disable then restart from sub-tick 0.
        div_int = 16'd2; slot_mask = '0; use_rem = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        repeat (7) @(negedge clk);
        run_vec('{16'd2, 16'h0000, 4'd0, 1'b0}, "R2");

        // R8: divisor change mid-period takes effect at the next period.
        enable = 1'b0;
        div_int = 16'd0; slot_mask = '0; use_rem = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        s1 = -1; s2 = -1;
        for (int c = 1; c <= 100; c++) begin
            if (c == 5) div_int = 16'd3;
            #1;
            if (bit_strobe === 1'b1) begin
                if (s1 < 0) s1 = c;
                else if (s2 < 0) s2 = c;
            end
            @(negedge clk);
        end
        check(s1 == 16, "R8 current period unchanged", s1, 16);
        check(s2 == 80, "R8 next period uses new divisor", s2, 80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule